// File: doc/BRIEF.md
# Sparsifying Token Ring Readout Sequencer

This block drains a large set of per-channel hit buffers onto one shared output stream. A token circulates around the channels. On each readout clock the sequencer finds, in one cycle, the first channel after the current token holder that holds data. It pops one entry from that channel and moves the token there. Empty channels cost no cycles. The result is an output stream with zero suppression, no gaps while data waits, and an even share of bandwidth across busy channels.

Each output word carries four fields:
- the serving channel's number in Gray code,
- the entry's timestamp in Gray code,
- the overflow flag of the entry,
- the pile-up flag of the entry.

A data-valid strobe qualifies the word. A channel that never empties is still served at most once per token pass. It cannot lock out the others or stall the ring.

Top module: `token_readout`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `out_valid` is 0 and no pop strobe is asserted. After reset the token is parked at channel NUM_CH-1, so the first search begins at channel 0.
- R2: In any cycle where at least one channel is non-empty, exactly one pop strobe is asserted. It goes to the first non-empty channel in ascending circular order, starting one past the token holder. The token then moves to that channel.
- R3: A channel whose not-empty flag is low is never popped. Empty channels are skipped within the same cycle.
- R4: One clock after a pop, `out_valid` is 1 and `out_chan` equals the popped channel index in Gray code (g = b XOR (b >> 1)).
- R5: In that same word, `out_ts` equals the popped entry's timestamp (bits [c*TS_W +: TS_W] of `ch_ts` for channel c) in Gray code.
- R6: The popped entry's overflow and pile-up flags appear unchanged on `out_ovf` and `out_pile` in that same word.
- R7: In a cycle where no channel has data, no pop is asserted, `out_valid` is 0 on the next clock, and the token does not move.
- R8: While every channel stays non-empty, any NUM_CH consecutive cycles pop each channel exactly once.
- R9: A channel that is the only one with data is served on every cycle. A continuously refilled channel never stalls the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_nonempty | input | NUM_CH | Per-channel flag: buffer holds at least one entry |
| ch_ts | input | NUM_CH*TS_W | Head-entry timestamps, channel c in bits [c*TS_W +: TS_W] |
| ch_ovf | input | NUM_CH | Head-entry overflow flag per channel |
| ch_pile | input | NUM_CH | Head-entry pile-up flag per channel |
| ch_pop | output | NUM_CH | One-hot pop strobe, combinational, acts at the clock edge |
| out_valid | output | 1 | Data-valid strobe for the output word |
| out_chan | output | CH_W | Gray-coded channel number |
| out_ts | output | TS_W | Gray-coded timestamp |
| out_ovf | output | 1 | Overflow flag passed through |
| out_pile | output | 1 | Pile-up flag passed through |

## Verification
Any fault in the token register shows at the ports within one cycle. A stale or corrupted token makes the next pop land on the wrong channel. One clock later, `out_chan` shows the wrong Gray code. A faulty search either pops an empty channel or asserts no pop while data waits. The reference model flags either case in the same cycle. The hard cases are a fill pattern that wraps past the last channel, and an idle gap during which the token must hold its position. A wrong priority in either case is visible only in the order of words that follows.

// File: rtl/token_readout_pkg.sv
package token_readout_pkg;

  // Binary to reflected Gray code, on a wide word; callers truncate.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/token_search.sv
module token_search #(
  parameter int NUM_CH = 128,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   holder,
  output logic              found,
  output logic [CH_W-1:0]   idx
);

  logic [NUM_CH-1:0] above_mask;
  logic [NUM_CH-1:0] req_above;

  // Lowest set bit of a vector; the index is meaningful only when any bit is set.
  function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_mask
      assign above_mask[g] = (CH_W'(g) > holder);
    end
  endgenerate

  assign req_above = req & above_mask;
  assign found     = |req;
  assign idx       = (|req_above) ? lowest_set(req_above) : lowest_set(req);

endmodule

// File: rtl/entry_select.sv
module entry_select #(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [CH_W-1:0]        idx,
  input  logic [NUM_CH*TS_W-1:0] ch_ts,
  input  logic [NUM_CH-1:0]      ch_ovf,
  input  logic [NUM_CH-1:0]      ch_pile,
  output logic [TS_W-1:0]        sel_ts,
  output logic                   sel_ovf,
  output logic                   sel_pile
);

  always_comb begin
    sel_ts   = '0;
    sel_ovf  = 1'b0;
    sel_pile = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == CH_W'(i)) begin
        sel_ts   = ch_ts[i*TS_W +: TS_W];
        sel_ovf  = ch_ovf[i];
        sel_pile = ch_pile[i];
      end
    end
  end

endmodule

// File: rtl/word_stage.sv
module word_stage #(
  parameter int CH_W = 7,
  parameter int TS_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] chan_bin,
  input  logic [TS_W-1:0] ts_bin,
  input  logic            ovf,
  input  logic            pile,
  output logic            valid_q,
  output logic [CH_W-1:0] chan_gray_q,
  output logic [TS_W-1:0] ts_gray_q,
  output logic            ovf_q,
  output logic            pile_q
);
  import token_readout_pkg::*;

  logic [31:0] chan_wide;
  logic [31:0] ts_wide;

  assign chan_wide = bin_to_gray(32'(chan_bin));
  assign ts_wide   = bin_to_gray(32'(ts_bin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      chan_gray_q <= '0;
      ts_gray_q   <= '0;
      ovf_q       <= 1'b0;
      pile_q      <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        chan_gray_q <= chan_wide[CH_W-1:0];
        ts_gray_q   <= ts_wide[TS_W-1:0];
        ovf_q       <= ovf;
        pile_q      <= pile;
      end
    end
  end

endmodule

// File: rtl/token_readout.sv
module token_readout #(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      ch_nonempty,
  input  logic [NUM_CH*TS_W-1:0] ch_ts,
  input  logic [NUM_CH-1:0]      ch_ovf,
  input  logic [NUM_CH-1:0]      ch_pile,
  output logic [NUM_CH-1:0]      ch_pop,
  output logic                   out_valid,
  output logic [CH_W-1:0]        out_chan,
  output logic [TS_W-1:0]        out_ts,
  output logic                   out_ovf,
  output logic                   out_pile
);

  localparam logic [CH_W-1:0] PARK = CH_W'(NUM_CH - 1);

  // Named internal events
  logic [CH_W-1:0] token_q;
  logic            win_found;
  logic [CH_W-1:0] win_idx;
  logic            serve_now;
  logic [TS_W-1:0] sel_ts;
  logic            sel_ovf;
  logic            sel_pile;

  token_search #(.NUM_CH(NUM_CH)) u_search (
    .req    (ch_nonempty),
    .holder (token_q),
    .found  (win_found),
    .idx    (win_idx)
  );

  entry_select #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_select (
    .idx      (win_idx),
    .ch_ts    (ch_ts),
    .ch_ovf   (ch_ovf),
    .ch_pile  (ch_pile),
    .sel_ts   (sel_ts),
    .sel_ovf  (sel_ovf),
    .sel_pile (sel_pile)
  );

  assign serve_now = rst_n && win_found;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_pop
      assign ch_pop[g] = serve_now && (win_idx == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         token_q <= PARK;
    else if (serve_now) token_q <= win_idx;
  end

  word_stage #(.CH_W(CH_W), .TS_W(TS_W)) u_word (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (serve_now),
    .chan_bin    (win_idx),
    .ts_bin      (sel_ts),
    .ovf         (sel_ovf),
    .pile        (sel_pile),
    .valid_q     (out_valid),
    .chan_gray_q (out_chan),
    .ts_gray_q   (out_ts),
    .ovf_q       (out_ovf),
    .pile_q      (out_pile)
  );

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_pop)); // R2
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (ch_pop & ~ch_nonempty) == '0); // R3
  AST_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (|ch_nonempty) |-> (|ch_pop)); // R9
  AST_WORD_FOLLOWS_POP: assert property (@(posedge clk) disable iff (!rst_n) (|ch_pop) |=> out_valid); // R4
  AST_IDLE_HOLDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n) !(|ch_nonempty) |=> (!out_valid && $stable(token_q))); // R7

endmodule

// File: tb/test_token_readout.sv
module test_token_readout;
  localparam int NCH = 16;
  localparam int TSW = 8;
  localparam int CW  = 4;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_CYC = 170;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   ch_nonempty = '0;
  logic [NCH*TSW-1:0] ch_ts = '0;
  logic [NCH-1:0]   ch_ovf = '0;
  logic [NCH-1:0]   ch_pile = '0;
  logic [NCH-1:0]   ch_pop;
  logic             out_valid;
  logic [CW-1:0]    out_chan;
  logic [TSW-1:0]   out_ts;
  logic             out_ovf;
  logic             out_pile;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int wd      = 0;

  // behavioural model state
  int cnt[NCH];
  int popped[NCH];
  int tok;
  int win_hist[NCH];
  int solo5;
  bit exp_valid;
  int exp_chan, exp_ts, exp_ovf, exp_pile;

  always #(CLK_PERIOD/2) clk = ~clk;

  token_readout #(.NUM_CH(NCH), .TS_W(TSW)) i_token_readout (
    .clk(clk), .rst_n(rst_n), .ch_nonempty(ch_nonempty), .ch_ts(ch_ts),
    .ch_ovf(ch_ovf), .ch_pile(ch_pile), .ch_pop(ch_pop), .out_valid(out_valid),
    .out_chan(out_chan), .out_ts(out_ts), .out_ovf(out_ovf), .out_pile(out_pile)
  );

  function automatic int gray_ref(int v, int w);
    int r = 0;
    for (int b = 0; b < w; b++) begin
      int hi = (b + 1 < w) ? ((v >> (b + 1)) & 1) : 0;
      r |= ((((v >> b) & 1) ^ hi) << b);
    end
    return r;
  endfunction

  function automatic int head_ts(int c, int p);  return (c * 11 + p * 5) % 256; endfunction
  function automatic int head_ovf(int c, int p); return (p % 3 == 2) ? 1 : 0;   endfunction
  function automatic int head_pile(int c, int p); return (c + p) % 2;          endfunction

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive();
    for (int c = 0; c < NCH; c++) begin
      ch_nonempty[c] = (cnt[c] > 0);
      ch_ts[c*TSW +: TSW] = TSW'(head_ts(c, popped[c]));
      ch_ovf[c]  = head_ovf(c, popped[c]) != 0;
      ch_pile[c] = head_pile(c, popped[c]) != 0;
    end
  endtask

  task automatic stimulus(int cyc);
    if (cyc == 10) begin cnt[9] += 1; cnt[3] += 2; end
    if (cyc == 20) for (int c = 0; c < NCH; c++) cnt[c] += 3;
    if (cyc >= 80 && cyc < 120) cnt[5] += 1;
    if (cyc == 100) begin cnt[12] += 1; cnt[2] += 1; end
    if (cyc == 130) cnt[15] += 1;
    if (cyc == 131) cnt[0] += 1;
    if (cyc == 140) cnt[7] += 1;
    if (cyc == 150) begin cnt[7] += 1; cnt[6] += 1; end
  endtask

  task automatic step(int cyc);
    int w;
    logic [NCH-1:0] exp_pop;
    @(negedge clk);
    // word registered at the edge just passed
    if (exp_valid) begin
      check("R4 valid", out_valid, 1);
      check("R4 chan", out_chan, gray_ref(exp_chan, CW));
      check("R5 ts", out_ts, gray_ref(exp_ts, TSW));
      check("R6 ovf", out_ovf, exp_ovf);
      check("R6 pile", out_pile, exp_pile);
    end else begin
      check("R7 idle valid", out_valid, 0);
    end
    stimulus(cyc);
    drive();
    #1;
    w = -1;
    for (int k = 1; k <= NCH; k++) begin
      int c = (tok + k) % NCH;
      if (w < 0 && cnt[c] > 0) w = c;
    end
    exp_pop = (w >= 0) ? (NCH'(1) << w) : '0;
    check("R2 pop", ch_pop, exp_pop);
    check("R3 no empty pop", ch_pop & ~ch_nonempty, 0);
    if (cyc >= 20 && cyc < 36) begin
      for (int c = 0; c < NCH; c++) if (ch_pop[c]) win_hist[c]++;
    end
    if (cyc >= 80 && cyc < 100 && ch_pop[5]) solo5++;
    if (w >= 0) begin
      exp_valid = 1;
      exp_chan  = w;
      exp_ts    = head_ts(w, popped[w]);
      exp_ovf   = head_ovf(w, popped[w]);
      exp_pile  = head_pile(w, popped[w]);
      cnt[w]--;
      popped[w]++;
      tok = w;
    end else begin
      exp_valid = 0;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (!done && wd > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin cnt[c] = 0; popped[c] = 0; win_hist[c] = 0; end
    tok = NCH - 1;
    solo5 = 0;
    exp_valid = 0;
    // R1: reset state, with data present so that gating is visible
    ch_nonempty = '1;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset valid", out_valid, 0);
      check("R1 reset pop", ch_pop, 0);
    end
    ch_nonempty = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < LAST_CYC; cyc++) step(cyc);
    // R8: each channel popped once in the 16-cycle window while all full
    for (int c = 0; c < NCH; c++) check("R8 share", win_hist[c], 1);
    // R9: lone continuously refilled channel served every cycle
    check("R9 solo service", solo5, 20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule